// File: doc/BRIEF.md
# Stereo Output Routing Mixer with Soft Mute

This block sits between a serial audio receiver and the downstream filter chain. It takes one aligned pair of signed left and right samples per input strobe and builds two output channels. Each output channel has its own source selection: silence, the right input, the left input, or the mono average of both inputs. A four-bit routing code therefore covers sixteen combinations, among them plain stereo, swapped channels, single-channel duplication and full mono.

A soft-mute request does not cut the signal at once. An eight-bit gain moves one step per input sample toward zero while the request is held, and back toward unity once it is released. Each routed sample is multiplied by that gain, so a full fade takes 255 samples in either direction and produces no audible click. The gain value 255 passes samples unchanged.

The two outputs are registered and come with a strobe one clock after the input strobe. Between strobes the outputs keep their last values.

Top module: `stereo_route_mixer`

## Requirements
- R1: While reset is low and after its release, out_valid, out_left and out_right read 0 and the gain starts at unity, so the first sample after reset passes unscaled.
- R2: out_valid equals in_valid delayed by exactly one clock. out_left and out_right change only in the clock after an in_valid cycle and otherwise hold their values.
- R3: route_code[3:2] picks the out_left source: 0 silence, 1 right input, 2 left input, 3 mono average.
- R4: route_code[1:0] picks the out_right source with the same encoding. Written MSB first, 4'b0000 silences both outputs, 4'b1001 is stereo, 4'b0110 swaps the channels and 4'b1111 puts mono on both.
- R5: The mono average is floor((L+R)/2), computed from a sum one bit wider than the samples so that it stays correct at full-scale inputs of either sign.
- R6: route_code is used only in cycles where in_valid is high. A change while in_valid is low leaves the outputs untouched.
- R7: With soft_mute high, each input sample lowers the gain by one until it reaches 0. Each output is floor(x*g/256), where x is the routed value and g is the gain before that sample's step. A gain of 255 is exact unity.
- R8: With soft_mute low, each input sample raises the gain by one until it reaches 255.
- R9: Once the gain has reached 0, both outputs are 0 for every routing code and input.
- R10: The gain changes only on cycles where in_valid is high. Idle cycles with soft_mute held do not move the fade.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe marking a valid left/right sample pair |
| in_left | input | 24 | Left input sample, signed two's complement |
| in_right | input | 24 | Right input sample, signed two's complement |
| route_code | input | 4 | [3:2] out_left source, [1:0] out_right source |
| soft_mute | input | 1 | Fade the output toward zero while high, back to unity while low |
| out_valid | output | 1 | Strobe one clock after in_valid |
| out_left | output | 24 | Left output sample, signed |
| out_right | output | 24 | Right output sample, signed |

## Verification
A wrong select decode or mono average shows up on the very next out_valid strobe as a value that differs from the bench's arithmetic. The sweep covers every routing code with full-scale, mixed-sign and small inputs. A wrong gain state, such as a missed step, a wrapped counter or a step on an idle cycle, does not stay hidden. Every sample in a complete fade is compared against a gain tracked independently in the bench, so the error shows on the first sample that carries the bad gain, and a wrap past zero or 255 shows within one sample of the end of the ramp.

// File: rtl/mix_pkg.sv
// mix_pkg: shared definitions for the stereo routing mixer.
// Assumes: source select codes are two bits wide and identical for both channels.
package mix_pkg;

    // Per-channel source selection code
    typedef enum logic [1:0] {
        SRC_SILENT = 2'd0,
        SRC_RIGHT  = 2'd1,
        SRC_LEFT   = 2'd2,
        SRC_MONO   = 2'd3
    } src_sel_e;

    // Number of output channels produced by the mixer
    localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/mix_source_sel.sv
// mix_source_sel: picks one channel's source among silence, right, left
// and the precomputed mono average.
// Assumes: the mono value is already averaged by the caller; purely combinational.
module mix_source_sel
    import mix_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24
) (
    input  logic signed [SAMPLE_W-1:0] left_in,
    input  logic signed [SAMPLE_W-1:0] right_in,
    input  logic signed [SAMPLE_W-1:0] mono_in,
    input  logic        [1:0]          sel,
    output logic signed [SAMPLE_W-1:0] src_out
);

    // Decode the two-bit source code into one sample
    always_comb begin
        unique case (src_sel_e'(sel))
            SRC_SILENT: src_out = '0;
            SRC_RIGHT:  src_out = right_in;
            SRC_LEFT:   src_out = left_in;
            SRC_MONO:   src_out = mono_in;
            default:    src_out = '0;
        endcase
    end

endmodule

// File: rtl/mix_gain_ramp.sv
// mix_gain_ramp: soft-mute gain counter. Moves one step per accepted
// sample toward zero (mute requested) or toward full scale (released).
// Assumes: step_en is high for exactly one clock per sample; reset is
// synchronous, active low, and leaves the gain at full scale.
module mix_gain_ramp #(
    parameter int unsigned GAIN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              mute_req,
    output logic [GAIN_W-1:0] gain
);

    localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};
    localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1);

    logic [GAIN_W-1:0] gain_q;

    // Step the gain once per sample, saturating at both ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= GAIN_MAX;
        end else if (step_en) begin
            if (mute_req && (gain_q != '0)) begin
                gain_q <= gain_q - GAIN_ONE;
            end else if (!mute_req && (gain_q != GAIN_MAX)) begin
                gain_q <= gain_q + GAIN_ONE;
            end
        end
    end

    assign gain = gain_q;

    // R7: a muting step lowers the gain by exactly one
    assert_ramp_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && mute_req && (gain_q != '0)) |=> (gain_q == $past(gain_q) - GAIN_ONE));

    // R8: a releasing step raises the gain by exactly one
    assert_ramp_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !mute_req && (gain_q != GAIN_MAX)) |=> (gain_q == $past(gain_q) + GAIN_ONE));

    // R10: no sample, no gain movement
    assert_gain_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(gain_q));

endmodule

// File: rtl/mix_gain_scale.sv
// mix_gain_scale: multiplies a signed sample by an unsigned gain and
// divides by 2**GAIN_W with floor rounding; full-scale gain bypasses.
// Assumes: gain is unsigned; purely combinational.
module mix_gain_scale #(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned GAIN_W   = 8
) (
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic        [GAIN_W-1:0]   gain,
    output logic signed [SAMPLE_W-1:0] sample_out
);

    localparam int unsigned PROD_W = SAMPLE_W + GAIN_W + 1;
    localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};

    logic signed [PROD_W-1:0] x_ext;
    logic signed [PROD_W-1:0] g_ext;
    logic signed [PROD_W-1:0] prod;
    logic                     unused_prod_bits;

    // Widen both operands so the product cannot overflow
    always_comb begin
        x_ext = PROD_W'(sample_in);
        g_ext = PROD_W'({1'b0, gain});
        prod  = x_ext * g_ext;
    end

    assign unused_prod_bits = ^{prod[PROD_W-1], prod[GAIN_W-1:0]};

    // Full-scale gain is exact unity; otherwise keep the shifted product
    always_comb begin
        if (gain == GAIN_MAX) begin
            sample_out = sample_in;
        end else begin
            sample_out = prod[SAMPLE_W+GAIN_W-1:GAIN_W];
        end
    end

endmodule

// File: rtl/stereo_route_mixer.sv
// stereo_route_mixer: routes an aligned stereo sample pair to two output
// channels (silence / right / left / mono each), applies the soft-mute
// gain and registers the result with a one-clock strobe delay.
// Assumes: in_left and in_right belong to the same frame; route_code and
// soft_mute are used only on strobe cycles; synchronous active-low reset.
module stereo_route_mixer
    import mix_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned GAIN_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic        [3:0]          route_code,
    input  logic                       soft_mute,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right
);

    localparam int unsigned SUM_W = SAMPLE_W + 1;

    logic signed [SUM_W-1:0]    pair_sum;
    logic signed [SAMPLE_W-1:0] mono_avg;
    logic                       unused_sum_lsb;
    logic        [1:0]          ch_sel    [NUM_CH];
    logic signed [SAMPLE_W-1:0] ch_src    [NUM_CH];
    logic signed [SAMPLE_W-1:0] ch_scaled [NUM_CH];
    logic        [GAIN_W-1:0]   gain;

    // Mono average: one-bit-wider sum, arithmetic shift right by one
    always_comb begin
        pair_sum = SUM_W'(in_left) + SUM_W'(in_right);
        mono_avg = pair_sum[SUM_W-1:1];
    end

    assign unused_sum_lsb = pair_sum[0];

    // Channel 0 is out_left (code bits 3:2), channel 1 is out_right (bits 1:0)
    assign ch_sel[0] = route_code[3:2];
    assign ch_sel[1] = route_code[1:0];

    // Soft-mute gain, stepped once per accepted sample
    mix_gain_ramp #(
        .GAIN_W (GAIN_W)
    ) gain_ramp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (in_valid),
        .mute_req (soft_mute),
        .gain     (gain)
    );

    // One source selector and one gain stage per output channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        mix_source_sel #(
            .SAMPLE_W (SAMPLE_W)
        ) sel_i (
            .left_in  (in_left),
            .right_in (in_right),
            .mono_in  (mono_avg),
            .sel      (ch_sel[ch]),
            .src_out  (ch_src[ch])
        );

        mix_gain_scale #(
            .SAMPLE_W (SAMPLE_W),
            .GAIN_W   (GAIN_W)
        ) scale_i (
            .sample_in  (ch_src[ch]),
            .gain       (gain),
            .sample_out (ch_scaled[ch])
        );
    end

    // Output register: capture on strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= ch_scaled[0];
                out_right <= ch_scaled[1];
            end
        end
    end

    // R2: strobe delayed by exactly one clock
    assert_strobe_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R2 / R6: outputs hold across idle cycles
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_left) && $stable(out_right)));

    // R3: silent code on the left selector gives a zero left output
    assert_left_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (route_code[3:2] == 2'd0)) |=> (out_left == '0));

    // R4: silent code on the right selector gives a zero right output
    assert_right_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (route_code[1:0] == 2'd0)) |=> (out_right == '0));

    // R9: zero gain silences both outputs
    assert_zero_gain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (gain == '0)) |=> ((out_left == '0) && (out_right == '0)));

endmodule

// File: tb/stereo_route_mixer_tb_top.sv
`timescale 1ns/1ps
module stereo_route_mixer_tb_top;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [23:0] in_left = '0;
    logic signed [23:0] in_right = '0;
    logic        [3:0]  route_code = 4'b1001;
    logic               soft_mute = 1'b0;
    logic               out_valid;
    logic signed [23:0] out_left;
    logic signed [23:0] out_right;

    int n_checks = 0;
    int n_fail   = 0;
    int model_gain = 255;

    always #4 clk = ~clk;

    stereo_route_mixer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_left    (in_left),
        .in_right   (in_right),
        .route_code (route_code),
        .soft_mute  (soft_mute),
        .out_valid  (out_valid),
        .out_left   (out_left),
        .out_right  (out_right)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Source value for a 2-bit select: 0 silent, 1 right, 2 left, 3 floor((L+R)/2)
    function automatic longint route_val(input int sel, input longint l, input longint r);
        case (sel)
            0: return 0;
            1: return r;
            2: return l;
            default: return (l + r) >>> 1;
        endcase
    endfunction

    function automatic longint scale_val(input longint v, input int g);
        if (g == 255) return v;
        return (v * g) >>> 8;
    endfunction

    // Send one sample, check the result one clock later, update model gain
    task automatic send(input string tag, input longint l, input longint r,
                        input logic [3:0] code, input logic mute);
        longint el, er;
        @(negedge clk);
        in_left    = 24'(l);
        in_right   = 24'(r);
        route_code = code;
        soft_mute  = mute;
        in_valid   = 1'b1;
        el = scale_val(route_val(int'(code[3:2]), l, r), model_gain);
        er = scale_val(route_val(int'(code[1:0]), l, r), model_gain);
        if (mute && model_gain > 0) model_gain--;
        else if (!mute && model_gain < 255) model_gain++;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R2 strobe"}, longint'(out_valid), 1);
        chk({tag, " left"}, longint'(out_left), el);
        chk({tag, " right"}, longint'(out_right), er);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        longint pl [8];
        longint pr [8];
        longint hold_l, hold_r;
        pl[0] =  64'sd8388607; pr[0] =  64'sd8388607;
        pl[1] = -64'sd8388608; pr[1] = -64'sd8388608;
        pl[2] =  64'sd8388607; pr[2] = -64'sd8388608;
        pl[3] =  64'sd123456;  pr[3] = -64'sd654321;
        pl[4] = -64'sd1;       pr[4] =  64'sd0;
        pl[5] =  64'sd1;       pr[5] =  64'sd2;
        pl[6] = -64'sd3;       pr[6] = -64'sd4;
        pl[7] =  64'sd4194304; pr[7] =  64'sd4194305;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset out_valid", longint'(out_valid), 0);
        chk("R1 reset out_left", longint'(out_left), 0);
        chk("R1 reset out_right", longint'(out_right), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-reset out_valid", longint'(out_valid), 0);

        // R1: first sample at unity gain passes unchanged (stereo 4'b1001)
        send("R1 unity first sample", -64'sd5000, 64'sd7000, 4'b1001, 1'b0);
        @(negedge clk);
        chk("R2 strobe low after sample", longint'(out_valid), 0);

        // R3/R4/R5: every routing code against every input pattern
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 8; p++) begin
                send("R3 R4 R5 route sweep", pl[p], pr[p], 4'(c), 1'b0);
            end
        end

        // R6: route change while idle leaves held outputs untouched
        send("R6 setup", 64'sd1000, 64'sd2000, 4'b1001, 1'b0);
        hold_l = longint'(out_left);
        hold_r = longint'(out_right);
        @(negedge clk);
        route_code = 4'b0000;
        in_left = 24'sd999;
        repeat (5) @(negedge clk);
        chk("R6 left held", longint'(out_left), hold_l);
        chk("R6 right held", longint'(out_right), hold_r);
        chk("R2 idle strobe", longint'(out_valid), 0);

        // R7/R9: full fade down with mono and stereo codes
        for (int i = 0; i < 140; i++) begin
            send("R7 fade down", 64'sd8388607 - 64'(i * 1111), -64'sd8388608 + 64'(i * 777),
                 (i % 2 == 0) ? 4'b1001 : 4'b1111, 1'b1);
        end
        // R10: idle cycles with mute held do not move the gain
        repeat (20) @(negedge clk);
        chk("R10 output held", longint'(out_valid), 0);
        send("R10 gain unchanged after idle", 64'sd3000001, -64'sd2999999, 4'b0110, 1'b1);
        for (int i = 0; i < 120; i++) begin
            send("R7 fade down", -64'sd7654321, 64'sd7654321, 4'b1001, 1'b1);
        end
        chk("R9 model gain reached zero", longint'(model_gain), 0);
        for (int c = 0; c < 16; c++) begin
            send("R9 zero gain", 64'sd8388607, -64'sd8388608, 4'(c), 1'b1);
        end

        // R8: release, ramp back to unity and beyond saturation
        for (int i = 0; i < 262; i++) begin
            send("R8 fade up", 64'sd5555555 - 64'(i * 3000), -64'sd4444444,
                 (i % 3 == 0) ? 4'b0110 : 4'b1111, 1'b0);
        end
        send("R8 unity restored", -64'sd8388608, 64'sd8388607, 4'b1001, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule